// File: doc/BRIEF.md
# Gate Slew-Rate Phase Sequencer

This block shapes one switching transition of an external power switch by playing a short profile of gate drive current codes. Each direction has its own four-step table. Turning on uses the charge table and turning off uses the discharge table. Each step holds one current code for a programmed number of 50 ns time-base ticks. The gate command enters as a level. The block registers it, and each change of level starts the table that belongs to the new direction, provided that table is enabled.

When no profile is running, the output is the static trim code for the present command level. The charge trim applies while the command is high and the discharge trim applies while it is low. The same static code is used when the matching table is disabled. A downstream current DAC consumes the active code. It can use the busy flag and the phase index to tell which step it is in.

Top module: `gate_slew_seq`

## Requirements
- R1: After reset, busy is 0, phase_idx is 0 and cur_code equals off_trim, because the registered command resets low.
- R2: Each table word holds four 8-bit slots. Step 1 is in bits 31:24, step 2 in bits 23:16, step 3 in bits 15:8 and step 4 in bits 7:0. Within a slot, bits 7:3 are the 5-bit current code and bits 2:0 are the 3-bit duration code.
- R3: A rising gate_cmd with on_seq_en=1 sets busy=1 and phase_idx=0 on the next clock edge. From that edge on, cur_code shows the current field of step 1 of on_table.
- R4: A step with duration code d lasts exactly d+1 cycles in which tick is 1. Cycles with tick=0 leave phase_idx and cur_code unchanged.
- R5: Steps run in the order 1, 2, 3, 4, and phase_idx reports them as 0, 1, 2, 3. While busy, cur_code is the current field of the active step.
- R6: After the last tick of step 4, busy drops to 0, phase_idx returns to 0 and cur_code shows the static trim code for the command level.
- R7: A command edge whose matching table is disabled does not set busy. cur_code then shows the static trim code directly: on_trim after a rising edge, off_trim after a falling edge.
- R8: A falling gate_cmd with off_seq_en=1 plays off_table under the same slot, ordering and timing rules as R2 to R6.
- R9: If the command reverses while a profile is running, that profile is aborted on the next edge. If the opposite table is enabled, it starts at step 1 with phase_idx=0. If it is disabled, busy drops and the static code is shown.
- R10: A current field of 0 in a step is passed to cur_code as 0 for the full duration of that step, which means slew control is off in that step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse of the 50 ns time base |
| gate_cmd | input | 1 | Gate command level (1 = switch on) |
| on_seq_en | input | 1 | Enables the turn-on table |
| off_seq_en | input | 1 | Enables the turn-off table |
| on_table | input | 32 | Turn-on step table |
| off_table | input | 32 | Turn-off step table |
| on_trim | input | 5 | Static charge current code |
| off_trim | input | 5 | Static discharge current code |
| cur_code | output | 5 | Active gate current code |
| busy | output | 1 | A profile is running |
| phase_idx | output | 2 | Active step, 0 to 3 |

## Verification
The hardest case to reach from the ports is a reversal of the command in the middle of a step. It must land with the tick counter part-way through a step that is neither the first nor the last. The stimulus advances a precise number of ticks into step 2 before it flips gate_cmd. It checks that the opposite table restarts at its own step 1 and that the partly used tick count is discarded. It then repeats the reversal with the opposite table disabled, to confirm that the block falls back to the static code.

// File: rtl/gate_slew_pkg.sv
package gate_slew_pkg;
    localparam int PHASES  = 4;
    localparam int SLOT_W  = 8;
    localparam int DUR_W   = 3;
    localparam int CUR_W   = 5;
    localparam int TABLE_W = PHASES * SLOT_W;
    localparam int PH_W    = $clog2(PHASES);

    typedef struct packed {
        logic [CUR_W-1:0] cur;
        logic [DUR_W-1:0] dur;
    } slot_t;

    typedef enum logic {
        DIR_OFF = 1'b0,
        DIR_ON  = 1'b1
    } dir_e;
endpackage

// File: rtl/gss_cmd_edge.sv
module gss_cmd_edge (
    input  logic clk,
    input  logic rst,
    input  logic cmd,
    output logic cmd_q,
    output logic rise,
    output logic fall
);
    always_ff @(posedge clk) begin
        if (rst) cmd_q <= 1'b0;
        else     cmd_q <= cmd;
    end

    assign rise = cmd & ~cmd_q;
    assign fall = ~cmd & cmd_q;
endmodule

// File: rtl/gss_phase_timer.sv
module gss_phase_timer
    import gate_slew_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             start,
    input  logic             abort,
    input  dir_e             start_dir,
    input  logic [DUR_W-1:0] dur_code,
    output logic             busy,
    output logic [PH_W-1:0]  phase,
    output dir_e             dir
);
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(PHASES - 1);

    logic [DUR_W-1:0] tcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            phase <= '0;
            tcnt  <= '0;
            dir   <= DIR_OFF;
        end else if (start) begin
            busy  <= 1'b1;
            phase <= '0;
            tcnt  <= '0;
            dir   <= start_dir;
        end else if (abort) begin
            busy  <= 1'b0;
            phase <= '0;
            tcnt  <= '0;
        end else if (busy && tick) begin
            if (tcnt == dur_code) begin
                tcnt <= '0;
                if (phase == LAST_PH) begin
                    busy  <= 1'b0;
                    phase <= '0;
                end else begin
                    phase <= phase + PH_W'(1);
                end
            end else begin
                tcnt <= tcnt + DUR_W'(1);
            end
        end
    end
endmodule

// File: rtl/gss_code_sel.sv
module gss_code_sel
    import gate_slew_pkg::*;
(
    input  logic               busy,
    input  dir_e               dir,
    input  logic [PH_W-1:0]    phase,
    input  logic               cmd_q,
    input  logic [TABLE_W-1:0] on_table,
    input  logic [TABLE_W-1:0] off_table,
    input  logic [CUR_W-1:0]   on_trim,
    input  logic [CUR_W-1:0]   off_trim,
    output logic [CUR_W-1:0]   cur_code,
    output logic [DUR_W-1:0]   dur_code
);
    slot_t on_slots  [PHASES];
    slot_t off_slots [PHASES];
    slot_t act_slot;

    // step 1 occupies the top slot, the last step the bottom slot
    for (genvar g = 0; g < PHASES; g++) begin : g_unpack
        assign on_slots[g]  = slot_t'(on_table [(PHASES-1-g)*SLOT_W +: SLOT_W]);
        assign off_slots[g] = slot_t'(off_table[(PHASES-1-g)*SLOT_W +: SLOT_W]);
    end

    always_comb begin
        act_slot = (dir == DIR_ON) ? on_slots[phase] : off_slots[phase];
        dur_code = act_slot.dur;
        if (busy)       cur_code = act_slot.cur;
        else if (cmd_q) cur_code = on_trim;
        else            cur_code = off_trim;
    end
endmodule

// File: rtl/gate_slew_seq.sv
module gate_slew_seq
    import gate_slew_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               gate_cmd,
    input  logic               on_seq_en,
    input  logic               off_seq_en,
    input  logic [TABLE_W-1:0] on_table,
    input  logic [TABLE_W-1:0] off_table,
    input  logic [CUR_W-1:0]   on_trim,
    input  logic [CUR_W-1:0]   off_trim,
    output logic [CUR_W-1:0]   cur_code,
    output logic               busy,
    output logic [PH_W-1:0]    phase_idx
);
    logic             cmd_q, rise, fall, start, abort;
    dir_e             dir, start_dir;
    logic [DUR_W-1:0] dur_code;

    gss_cmd_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .cmd   (gate_cmd),
        .cmd_q (cmd_q),
        .rise  (rise),
        .fall  (fall)
    );

    // a new edge always cancels a running profile; it restarts only if enabled
    assign start     = (rise & on_seq_en) | (fall & off_seq_en);
    assign abort     = (rise | fall) & ~start;
    assign start_dir = rise ? DIR_ON : DIR_OFF;

    gss_phase_timer u_timer (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .start     (start),
        .abort     (abort),
        .start_dir (start_dir),
        .dur_code  (dur_code),
        .busy      (busy),
        .phase     (phase_idx),
        .dir       (dir)
    );

    gss_code_sel u_sel (
        .busy      (busy),
        .dir       (dir),
        .phase     (phase_idx),
        .cmd_q     (cmd_q),
        .on_table  (on_table),
        .off_table (off_table),
        .on_trim   (on_trim),
        .off_trim  (off_trim),
        .cur_code  (cur_code),
        .dur_code  (dur_code)
    );
endmodule

// File: rtl/gate_slew_seq_chk.sv
module gate_slew_seq_chk
    import gate_slew_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             gate_cmd,
    input logic             on_seq_en,
    input logic             off_seq_en,
    input logic [CUR_W-1:0] on_trim,
    input logic [CUR_W-1:0] off_trim,
    input logic [CUR_W-1:0] cur_code,
    input logic             busy,
    input logic [PH_W-1:0]  phase_idx
);
    logic cmd_seen;
    logic cmd_edge;

    always_ff @(posedge clk) begin
        if (rst) cmd_seen <= 1'b0;
        else     cmd_seen <= gate_cmd;
    end

    assign cmd_edge = gate_cmd != cmd_seen;

    AST_ON_START: assert property (@(posedge clk) disable iff (rst)
        (gate_cmd && !cmd_seen && on_seq_en) |=> (busy && phase_idx == '0)); // R3
    AST_OFF_START: assert property (@(posedge clk) disable iff (rst)
        (!gate_cmd && cmd_seen && off_seq_en) |=> (busy && phase_idx == '0)); // R8
    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (rst)
        (cmd_edge && !(gate_cmd ? on_seq_en : off_seq_en)) |=> !busy); // R7
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick && !cmd_edge) |=> (busy && $stable(phase_idx))); // R4
    AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (rst)
        (busy && tick && !cmd_edge) |=> (phase_idx == $past(phase_idx)
            || phase_idx == $past(phase_idx) + PH_W'(1)
            || (!busy && phase_idx == '0))); // R5
    AST_IDLE_STATIC: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (phase_idx == '0 && cur_code == (cmd_seen ? on_trim : off_trim))); // R6
endmodule

bind gate_slew_seq gate_slew_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .gate_cmd   (gate_cmd),
    .on_seq_en  (on_seq_en),
    .off_seq_en (off_seq_en),
    .on_trim    (on_trim),
    .off_trim   (off_trim),
    .cur_code   (cur_code),
    .busy       (busy),
    .phase_idx  (phase_idx)
);

// File: tb/gate_slew_seq_tb.sv
module gate_slew_seq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        gate_cmd = 1'b0;
    logic        on_seq_en = 1'b0;
    logic        off_seq_en = 1'b0;
    logic [31:0] on_table = '0;
    logic [31:0] off_table = '0;
    logic [4:0]  on_trim = 5'h0A;
    logic [4:0]  off_trim = 5'h03;
    logic [4:0]  cur_code;
    logic        busy;
    logic [1:0]  phase_idx;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    int on_cur [4];
    int on_dur [4];
    int off_cur [4];
    int off_dur [4];

    always #2 clk = ~clk;

    gate_slew_seq u_dut (
        .clk(clk), .rst(rst), .tick(tick), .gate_cmd(gate_cmd),
        .on_seq_en(on_seq_en), .off_seq_en(off_seq_en),
        .on_table(on_table), .off_table(off_table),
        .on_trim(on_trim), .off_trim(off_trim),
        .cur_code(cur_code), .busy(busy), .phase_idx(phase_idx)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one clock; called and returns at a falling edge
    task automatic step(input logic t);
        tick = t;
        @(posedge clk);
        @(negedge clk);
        tick = 1'b0;
    endtask

    // R2 slot layout: step 1 in bits 31:24, current in slot bits 7:3, duration in 2:0
    function automatic logic [31:0] pack(input int c[4], input int d[4]);
        logic [31:0] w = '0;
        for (int i = 0; i < 4; i++)
            w[(3-i)*8 +: 8] = {c[i][4:0], d[i][2:0]};
        return w;
    endfunction

    // walks a full profile already started, checking each step and idle tick
    task automatic walk(input string req, input int c[4], input int d[4],
                        input int static_code);
        for (int p = 0; p < 4; p++) begin
            for (int k = 0; k <= d[p]; k++) begin
                check({req, " busy"}, busy, 1);
                check({req, " phase order R5"}, phase_idx, p);
                check({req, " step code R5"}, cur_code, c[p]);
                if (k == 0) begin
                    step(1'b0);
                    check("R4 no-tick hold", phase_idx, p);
                end
                step(1'b1);
            end
        end
        check("R6 busy end", busy, 0);
        check("R6 phase end", phase_idx, 0);
        check("R6 static code", cur_code, static_code);
    endtask

    task automatic t_reset;
        check("R1 busy", busy, 0);
        check("R1 phase", phase_idx, 0);
        check("R1 code", cur_code, off_trim);
    endtask

    task automatic t_on_profile;
        on_seq_en = 1'b1;
        gate_cmd  = 1'b1;
        step(1'b0);
        check("R3 start busy", busy, 1);
        check("R3 start phase", phase_idx, 0);
        check("R3 step1 code", cur_code, on_cur[0]);
        walk("R2", on_cur, on_dur, on_trim);
    endtask

    task automatic t_off_profile;
        off_seq_en = 1'b1;
        gate_cmd   = 1'b0;
        step(1'b0);
        walk("R8", off_cur, off_dur, off_trim);
    endtask

    task automatic t_disabled;
        on_seq_en = 1'b0;
        gate_cmd  = 1'b1;
        step(1'b1);
        check("R7 no busy on", busy, 0);
        check("R7 trim on", cur_code, on_trim);
        off_seq_en = 1'b0;
        gate_cmd   = 1'b0;
        step(1'b0);
        check("R7 no busy off", busy, 0);
        check("R7 trim off", cur_code, off_trim);
        off_seq_en = 1'b1;
    endtask

    task automatic t_reverse;
        on_seq_en = 1'b1;
        gate_cmd  = 1'b1;
        step(1'b0);
        for (int i = 0; i <= on_dur[0]; i++) step(1'b1);
        step(1'b1);  // partway into step 2 (duration 2)
        check("R9 setup phase", phase_idx, 1);
        gate_cmd = 1'b0;
        step(1'b0);
        check("R9 restart busy", busy, 1);
        check("R9 restart phase", phase_idx, 0);
        check("R9 restart code", cur_code, off_cur[0]);
        // opposite table disabled: reversal drops to static
        on_seq_en = 1'b0;
        gate_cmd  = 1'b1;
        step(1'b0);
        check("R9 abort busy", busy, 0);
        check("R9 abort code", cur_code, on_trim);
        gate_cmd = 1'b0;
        step(1'b0);
        walk("R9 clean", off_cur, off_dur, off_trim);
    endtask

    task automatic t_zero_code;
        check("R10 zero current step", on_cur[2], 0);
        on_seq_en = 1'b1;
        gate_cmd  = 1'b1;
        step(1'b0);
        for (int i = 0; i <= on_dur[0]; i++) step(1'b1);
        for (int i = 0; i <= on_dur[1]; i++) step(1'b1);
        for (int k = 0; k <= on_dur[2]; k++) begin
            check("R10 phase", phase_idx, 2);
            check("R10 code zero", cur_code, 0);
            step(1'b1);
        end
        check("R10 next step", cur_code, on_cur[3]);
    endtask

    initial begin
        on_cur  = '{17, 9, 0, 31};
        on_dur  = '{1, 2, 3, 0};
        off_cur = '{6, 20, 1, 12};
        off_dur = '{0, 7, 1, 2};
        on_table  = pack(on_cur, on_dur);
        off_table = pack(off_cur, off_dur);
        @(negedge clk);
        step(1'b0);
        step(1'b0);
        rst = 1'b0;
        t_reset();
        t_on_profile();
        t_off_profile();
        t_disabled();
        t_reverse();
        t_zero_code();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule